// File: doc/BRIEF.md
# Ethernet Transmit Framer with Minimum-Length Padding

This block turns a payload byte stream and a set of header values into a complete Ethernet frame, one byte per clock. A frame begins with a single-cycle `start` request that carries the destination address, source address, length/type value, an optional tag control word and a gap length. The framer then waits until the carrier input has stayed low for the programmed number of cycles. After that it sends the preamble, the start delimiter, the header, the payload, zero padding and a 32-bit frame check sequence.

The payload arrives on a valid/ready stream that has a last marker. The framer holds `pl_ready` low while it sends the preamble and the header. It raises `pl_ready` only during the data phase and sends each accepted byte on the next cycle. If the body is short, the framer adds zero bytes until the span from the destination address through the check sequence reaches 64 bytes. The check sequence is computed over that whole span except the check sequence itself. Collision handling, backoff and line coding belong to other blocks.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, and at any time no frame is in progress, `tx_valid`, `busy` and `pl_ready` are low.
- R2: Let G be `ifg_gap`, with 0 treated as 1. With carrier low, the first byte appears on `tx_valid` G+1 cycles after the edge that accepts `start`. Any cycle with `carrier` high during the wait restarts the count. Once the preamble has begun, `carrier` has no effect.
- R3: Each frame begins with seven bytes of 0x55, followed by the delimiter byte 0xD5 (bit pattern 10101011 sent least significant bit first).
- R4: After the delimiter come the destination address (6 bytes), then the source address (6 bytes), then the length/type value (2 bytes). Each of these is sent most significant byte first. All of these values are sampled in the cycle in which `start` is accepted.
- R5: When `tag_en` is set, the bytes 0x81, 0x00 and then `tag_ctl` (most significant byte first) are inserted between the source address and the length/type field.
- R6: Zero bytes follow the payload until the bytes from the destination address through the last pad byte number at least 60. That is 46 data-plus-pad bytes without a tag and 42 with one. No pad byte is sent when the payload already meets that length.
- R7: The last four bytes carry the bit-complement of a CRC-32 (reflected polynomial 0xEDB88320, register preset to all ones). The CRC covers the bytes from the destination address through the pad, and the check bytes are sent least significant byte first. Running the same CRC over the whole body including the check bytes leaves 0xDEBB20E3.
- R8: `pl_ready` is high only during the data phase. A byte taken when `pl_valid` and `pl_ready` are both high appears on `tx_data` in the next cycle. A cycle without `pl_valid` produces a cycle without `tx_valid` and leaves the frame content unchanged.
- R9: `busy` is high from the accepting edge until the last check byte has been presented. A `start` that arrives while `busy` is high is ignored, and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame request; accepted only while `busy` is low |
| dst_addr | input | 48 | Destination address, sampled on accept |
| src_addr | input | 48 | Source address, sampled on accept |
| len_type | input | 16 | Length/type value, sampled on accept |
| tag_en | input | 1 | Insert the tag type and tag control word |
| tag_ctl | input | 16 | Tag control word |
| ifg_gap | input | GAP_W | Required number of quiet carrier cycles |
| carrier | input | 1 | Medium activity indication |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | Payload byte valid |
| pl_last | input | 1 | Marks the final payload byte |
| pl_ready | output | 1 | Framer accepts a payload byte |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | `tx_data` holds a frame byte |
| busy | output | 1 | Frame in progress |

## Verification
The end of the payload and the minimum-length threshold can fall in the same cycle. In that cycle the framer must choose between padding and the check sequence. The bench provokes this case with payloads of exactly 46 bytes (untagged) and 42 bytes (tagged), and also with lengths one byte shorter, both with and without payload stalls. Each result is judged by the total byte count, by a byte-for-byte comparison of the pad and check regions against a model built from the requirements, and by the CRC residue over the received body.

// File: rtl/eth_tx_pkg.sv
// Shared types, constants and the CRC step function for the transmit framer.
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEFER, ST_PRE, ST_SFD, ST_HDR, ST_DATA, ST_PAD, ST_FCS
    } tx_state_t;

    localparam logic [7:0]  PREAMBLE_OCTET = 8'h55;
    localparam logic [7:0]  SFD_OCTET      = 8'hD5;
    localparam logic [15:0] TAG_TYPE       = 16'h8100;
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB88320;
    localparam int          HDR_PLAIN      = 14;
    localparam int          HDR_TAGGED     = 18;

    // Advance a reflected CRC-32 register by one byte, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_defer.sv
// Deferral timer: counts consecutive quiet carrier cycles while armed and
// raises go in the cycle the programmed gap is reached. A gap of 0 acts as 1.
// Assumes arm stays high until go is seen.
module eth_tx_defer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             carrier,
    input  logic [GAP_W-1:0] gap,
    output logic             go
);

    logic [GAP_W-1:0] quiet_q;
    logic [GAP_W:0]   quiet_inc;

    assign quiet_inc = {1'b0, quiet_q} + {{GAP_W{1'b0}}, 1'b1};
    assign go        = arm && !carrier && (quiet_inc >= {1'b0, gap});

    // Quiet-cycle counter; any activity or the end of waiting clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= '0;
        end else if (!arm || carrier || go) begin
            quiet_q <= '0;
        end else begin
            quiet_q <= quiet_inc[GAP_W-1:0];
        end
    end

endmodule

// File: rtl/eth_tx_crc.sv
// Frame check register: preset on clear, advanced by one byte on en.
// Assumes clear and en are never high together.
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);

    // CRC state register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= '1;
        end else if (en) begin
            crc_q <= crc32_step(crc_q, din);
        end
    end

endmodule

// File: rtl/eth_tx_hdr.sv
// Header byte selector: maps a header index to the byte sent at that
// position, for both the plain and the tagged layout, and flags the last one.
// Assumes idx stays below the header length of the selected layout.
module eth_tx_hdr
    import eth_tx_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [47:0]      dst,
    input  logic [47:0]      src,
    input  logic [15:0]      len_type,
    input  logic             tag_en,
    input  logic [15:0]      tag_ctl,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       hdr_byte,
    output logic             hdr_last
);

    logic [HDR_TAGGED*8-1:0] hvec;
    logic [7:0]              hb [HDR_TAGGED];

    assign hvec = tag_en ? {dst, src, TAG_TYPE, tag_ctl, len_type}
                         : {dst, src, len_type, 32'h0};

    // Slice the header vector into bytes, first-sent byte at index 0.
    for (genvar g = 0; g < HDR_TAGGED; g++) begin : g_slice
        assign hb[g] = hvec[(HDR_TAGGED-1-g)*8 +: 8];
    end

    // Select the byte for the current position.
    always_comb begin
        hdr_byte = 8'h00;
        for (int k = 0; k < HDR_TAGGED; k++) begin
            if (idx == IDX_W'(k)) hdr_byte = hb[k];
        end
    end

    assign hdr_last = (idx == (tag_en ? IDX_W'(HDR_TAGGED-1) : IDX_W'(HDR_PLAIN-1)));

endmodule

// File: rtl/eth_tx_framer.sv
// Transmit framer top: latches the header on start, defers for the gap,
// then sends preamble, delimiter, header, payload, zero pad and FCS, one
// registered byte per cycle. Assumes the payload holds at least one byte.
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int GAP_W    = 8,
    parameter int MIN_BODY = 60,
    parameter int PRE_LEN  = 7,
    parameter int FCS_LEN  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [47:0]      dst_addr,
    input  logic [47:0]      src_addr,
    input  logic [15:0]      len_type,
    input  logic             tag_en,
    input  logic [15:0]      tag_ctl,
    input  logic [GAP_W-1:0] ifg_gap,
    input  logic             carrier,
    input  logic [7:0]       pl_data,
    input  logic             pl_valid,
    input  logic             pl_last,
    output logic             pl_ready,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    output logic             busy
);

    localparam int CNT_W = $clog2(MIN_BODY + 1);
    localparam int IDX_W = $clog2(HDR_TAGGED);

    tx_state_t        state_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] body_q, body_next;
    logic             body_full_next;
    logic [47:0]      dst_q, src_q;
    logic [15:0]      lt_q, tagc_q;
    logic             tag_q;
    logic [GAP_W-1:0] gap_q;
    logic             accept, go, hdr_last, emit, body_en;
    logic [7:0]       hdr_byte, out_byte;
    logic [31:0]      crc_q;

    assign busy     = (state_q != ST_IDLE) || tx_valid;
    assign accept   = start && !busy;
    assign pl_ready = (state_q == ST_DATA);

    assign body_next      = (body_q >= CNT_W'(MIN_BODY)) ? body_q : body_q + CNT_W'(1);
    assign body_full_next = (body_next >= CNT_W'(MIN_BODY));

    eth_tx_defer #(.GAP_W(GAP_W)) u_defer (
        .clk(clk), .rst_n(rst_n), .arm(state_q == ST_DEFER),
        .carrier(carrier), .gap(gap_q), .go(go)
    );

    eth_tx_hdr #(.IDX_W(IDX_W)) u_hdr (
        .dst(dst_q), .src(src_q), .len_type(lt_q), .tag_en(tag_q),
        .tag_ctl(tagc_q), .idx(idx_q), .hdr_byte(hdr_byte), .hdr_last(hdr_last)
    );

    eth_tx_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .en(body_en),
        .din(out_byte), .crc_q(crc_q)
    );

    // Choose the byte for this cycle and whether it enters the CRC.
    always_comb begin
        emit     = 1'b0;
        body_en  = 1'b0;
        out_byte = 8'h00;
        case (state_q)
            ST_PRE:  begin emit = 1'b1; out_byte = PREAMBLE_OCTET; end
            ST_SFD:  begin emit = 1'b1; out_byte = SFD_OCTET; end
            ST_HDR:  begin emit = 1'b1; body_en = 1'b1; out_byte = hdr_byte; end
            ST_DATA: begin emit = pl_valid; body_en = pl_valid; out_byte = pl_data; end
            ST_PAD:  begin emit = 1'b1; body_en = 1'b1; out_byte = 8'h00; end
            ST_FCS:  begin emit = 1'b1; out_byte = ~crc_q[{idx_q[1:0], 3'b000} +: 8]; end
            default: ;
        endcase
    end

    // Frame sequencer with header latch and byte/position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            body_q  <= '0;
            dst_q   <= '0;
            src_q   <= '0;
            lt_q    <= '0;
            tagc_q  <= '0;
            tag_q   <= 1'b0;
            gap_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    dst_q   <= dst_addr;
                    src_q   <= src_addr;
                    lt_q    <= len_type;
                    tag_q   <= tag_en;
                    tagc_q  <= tag_ctl;
                    gap_q   <= ifg_gap;
                    state_q <= ST_DEFER;
                end
                ST_DEFER: if (go) begin
                    idx_q   <= '0;
                    state_q <= ST_PRE;
                end
                ST_PRE: begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (idx_q == IDX_W'(PRE_LEN - 1)) state_q <= ST_SFD;
                end
                ST_SFD: begin
                    idx_q   <= '0;
                    body_q  <= '0;
                    state_q <= ST_HDR;
                end
                ST_HDR: begin
                    idx_q  <= idx_q + IDX_W'(1);
                    body_q <= body_next;
                    if (hdr_last) state_q <= ST_DATA;
                end
                ST_DATA: if (pl_valid) begin
                    body_q <= body_next;
                    if (pl_last) begin
                        idx_q   <= '0;
                        state_q <= body_full_next ? ST_FCS : ST_PAD;
                    end
                end
                ST_PAD: begin
                    body_q <= body_next;
                    if (body_full_next) begin
                        idx_q   <= '0;
                        state_q <= ST_FCS;
                    end
                end
                ST_FCS: begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (idx_q == IDX_W'(FCS_LEN - 1)) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Registered byte output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= 8'h00;
        end else begin
            tx_valid <= emit;
            tx_data  <= out_byte;
        end
    end

endmodule

// File: rtl/eth_tx_framer_chk.sv
// Port-level protocol checker for the transmit framer, bound to every instance.
module eth_tx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pl_data,
    input logic       pl_valid,
    input logic       pl_ready,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       busy
);

    assert_idle_no_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pl_ready);

    assert_defer_first_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> !tx_valid);

    assert_ready_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> busy);

    assert_stall_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_ready && !pl_valid) |=> !tx_valid);

    assert_data_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_ready && pl_valid) |=> (tx_valid && tx_data == $past(pl_data)));

    assert_busy_end_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx_valid));

endmodule

bind eth_tx_framer eth_tx_framer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pl_data(pl_data), .pl_valid(pl_valid),
    .pl_ready(pl_ready), .tx_data(tx_data), .tx_valid(tx_valid), .busy(busy)
);

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;

    localparam logic [47:0] DST = 48'h0A1B2C3D4E5F;
    localparam logic [47:0] SRC = 48'h112233445566;
    localparam int NVEC = 7;
    // {gap[31:24], tag[23], stall[22], mid_carrier[21], busy_start[20], hold[19:16], len[15:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd4, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd1},
        {8'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 16'd46},
        {8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd45},
        {8'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 16'd42},
        {8'd2, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 16'd41},
        {8'd6, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 16'd100},
        {8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 16'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] dst_addr = '0, src_addr = '0;
    logic [15:0] len_type = '0, tag_ctl = '0;
    logic        tag_en = 1'b0;
    logic [7:0]  ifg_gap = '0;
    logic        carrier = 1'b0;
    logic [7:0]  pl_data = '0;
    logic        pl_valid = 1'b0, pl_last = 1'b0;
    logic        pl_ready, tx_valid, busy;
    logic [7:0]  tx_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_b [256];
    logic [7:0] got_b [256];

    always #4 clk = ~clk;

    eth_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_addr(dst_addr),
        .src_addr(src_addr), .len_type(len_type), .tag_en(tag_en),
        .tag_ctl(tag_ctl), .ifg_gap(ifg_gap), .carrier(carrier),
        .pl_data(pl_data), .pl_valid(pl_valid), .pl_last(pl_last),
        .pl_ready(pl_ready), .tx_data(tx_data), .tx_valid(tx_valid), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] pay(input int i, input int len);
        return 8'((i * 13 + len + 7) & 255);
    endfunction

    // Serial CRC-32 model, one data bit at a time.
    function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [7:0] d);
        logic fb;
        for (int b = 0; b < 8; b++) begin
            fb = c[0] ^ d[b];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    task automatic region(input int lo, input int hi, input int ncap, input string req,
                          input string what);
        int bad = -1;
        for (int i = lo; i < hi; i++) begin
            if (bad < 0 && (i >= ncap || got_b[i] !== exp_b[i])) bad = i;
        end
        if (bad < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, {what, " byte mismatch"},
                   (bad < ncap) ? longint'(got_b[bad]) : -1, longint'(exp_b[bad]));
    endtask

    task automatic run_frame(input logic [31:0] v);
        int gap = int'(v[31:24]);
        bit tag = v[23], stall = v[22], midc = v[21], pulse = v[20];
        int hold = int'(v[19:16]);
        int len = int'(v[15:0]);
        int hl = tag ? 18 : 14;
        int body, total, p, m, ncap, first_v, first_r, pi, cyc, act;
        bit take;
        logic [15:0] tc = 16'hA5C3 ^ 16'(len);
        logic [31:0] c;

        // Expected frame built from the requirements.
        p = 0;
        for (int i = 0; i < 7; i++) exp_b[p++] = 8'h55;
        exp_b[p++] = 8'hD5;
        for (int k = 0; k < 6; k++) exp_b[p++] = DST[47 - 8*k -: 8];
        for (int k = 0; k < 6; k++) exp_b[p++] = SRC[47 - 8*k -: 8];
        if (tag) begin
            exp_b[p++] = 8'h81; exp_b[p++] = 8'h00;
            exp_b[p++] = tc[15:8]; exp_b[p++] = tc[7:0];
        end
        exp_b[p++] = 8'(len >> 8); exp_b[p++] = 8'(len);
        for (int i = 0; i < len; i++) exp_b[p++] = pay(i, len);
        while (p - 8 < 60) exp_b[p++] = 8'h00;
        body = p;
        c = 32'hFFFFFFFF;
        for (int i = 8; i < body; i++) c = crc_bits(c, exp_b[i]);
        for (int k = 0; k < 4; k++) exp_b[p++] = ~c[8*k +: 8];
        total = p;

        @(negedge clk);
        start = 1'b1; dst_addr = DST; src_addr = SRC; len_type = 16'(len);
        tag_en = tag; tag_ctl = tc; ifg_gap = 8'(gap); carrier = (hold > 0);
        @(posedge clk);
        m = 0; ncap = 0; first_v = -1; first_r = -1; pi = 0; cyc = 0;
        forever begin
            @(negedge clk);
            if (tx_valid) begin
                if (first_v < 0) first_v = m;
                if (ncap < 256) got_b[ncap] = tx_data;
                ncap++;
            end
            if (pl_ready && first_r < 0) first_r = ncap;
            if (m > 0 && !busy) break;
            if (m > 3000) begin
                check(1'b0, "R9", "frame did not finish", m, 0);
                break;
            end
            start = pulse && (ncap == 20);
            if (m == 0) begin
                // Inputs change after accept: the latched copies must be used.
                dst_addr = '1; src_addr = 48'h0; len_type = 16'hFFFF;
                tag_en = ~tag; tag_ctl = 16'h0;
            end
            carrier = (m < hold) || (midc && ncap > 0);
            if (pi < len) begin
                pl_valid = !(stall && (cyc % 3 == 1));
                pl_data  = pay(pi, len);
                pl_last  = (pi == len - 1);
            end else begin
                pl_valid = 1'b0; pl_last = 1'b0;
            end
            take = pl_valid && pl_ready;
            cyc++;
            @(posedge clk);
            if (take) pi++;
            m++;
        end
        start = 1'b0; carrier = 1'b0; pl_valid = 1'b0; pl_last = 1'b0;

        check(first_v == hold + ((gap < 1) ? 1 : gap) + 1, "R2", "first byte latency",
              first_v, hold + ((gap < 1) ? 1 : gap) + 1);
        check(first_r == 8 + hl, "R8", "bytes sent before ready", first_r, 8 + hl);
        check(ncap == total, "R6", "frame length", ncap, total);
        region(0, 8, ncap, "R3", "preamble/delimiter");
        region(8, 20, ncap, "R4", "addresses");
        if (tag) region(20, 24, ncap, "R5", "tag fields");
        region(8 + hl - 2, 8 + hl, ncap, "R4", "length/type");
        region(8 + hl, body, ncap, "R6", "data and pad");
        region(body, total, ncap, "R7", "check bytes");
        c = 32'hFFFFFFFF;
        for (int i = 8; i < ncap && i < 256; i++) c = crc_bits(c, got_b[i]);
        check(c == 32'hDEBB20E3, "R7", "CRC residue", c, 32'hDEBB20E3);
        act = 0;
        repeat (20) begin
            @(negedge clk);
            if (tx_valid || busy) act++;
        end
        check(act == 0, "R9", "activity after frame", act, 0);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog expired: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!tx_valid && !busy && !pl_ready, "R1", "outputs in reset",
              {tx_valid, busy, pl_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!tx_valid && !busy && !pl_ready, "R1", "outputs idle after reset",
              {tx_valid, busy, pl_ready}, 0);

        // Vector table: frame shapes around the padding threshold.
        for (int i = 0; i < NVEC; i++) run_frame(VEC[i]);

        // Directed: reset in the middle of a frame returns to idle (R1).
        @(negedge clk);
        start = 1'b1; ifg_gap = 8'd1; tag_en = 1'b0; carrier = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check(busy && tx_valid, "R1", "frame running before reset", {busy, tx_valid}, 3);
        rst_n = 1'b0;
        @(negedge clk);
        check(!tx_valid && !busy && !pl_ready, "R1", "outputs after mid-frame reset",
              {tx_valid, busy, pl_ready}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!tx_valid && !busy, "R1", "idle after mid-frame reset", {tx_valid, busy}, 0);

        // Directed: one more frame after reset still meets the latency rule.
        run_frame({8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 16'd60});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule